// File: doc/BRIEF.md
# I2C Bit-Level Target Bridge

This block sits behind the sampled SCL and SDA levels of a two-wire bus and plays the target side of the protocol one bit at a time. It detects START and STOP conditions, collects the address byte and any write bytes, and hands each complete byte to a downstream target port. That port answers in the same cycle whether it accepts the byte. The bridge turns the answer into an ACK or a NACK on the bus. For reads, it fetches a byte from the downstream port and shifts it out MSB first. It then looks at the controller's acknowledge to decide whether to fetch another byte or to park.

The bridge has one open-drain data output. That output is combined with the stored controller SDA level to give the wire level that both sides see. Every action is keyed to a change in one of the two input levels. A clock cycle in which neither line changes does nothing. The downstream operation code is combinational in the cycle in which the triggering level change is presented. The data drive is registered and takes its new value at the clock edge that closes that cycle.

Top module: `i2c_bit_target`

## Requirements
- R1: After reset, `sda_drive` and `sda_bus` are 1 and `tgt_op` is 0 (none), with both stored line levels at 1.
- R2: SDA falling while the stored SCL is 1 is START. The block enters the first receive bit and forgets any latched address, with no operation issued (this includes a repeated START with no STOP before it).
- R3: An SDA change while the stored SCL is 0, or a cycle that repeats the current level of both lines, issues no operation and leaves the drive unchanged.
- R4: Every SCL falling edge sets `sda_drive` to 1.
- R5: In receive, each SCL rising edge shifts the stored SDA in, so the first bit ends as the MSB. On the ninth rising edge, the first byte after START is issued as op 1 (start transfer) with `tgt_addr` = byte[7:1] and `tgt_rnw` = byte[0]. Later bytes are issued as op 2 (write byte) on `tgt_wdata`.
- R6: If `tgt_accept` is 1 for op 1 or op 2, `sda_drive` becomes 0 on that edge. The block then reads if the accepted address had `tgt_rnw` = 1, and otherwise receives the next byte.
- R7: If `tgt_accept` is 0 for op 1 or op 2, `sda_drive` stays 1, the address is dropped and op 5 (end transfer) is issued in the next cycle. Further clocks then issue nothing and leave the drive at 1 until START.
- R8: In read, the first SCL rising edge of each byte issues op 3 (read byte), and `tgt_rdata` is taken in that cycle. The eight rising edges of the byte drive its bits MSB first.
- R9: On the rising edge after a read byte, a stored SDA of 0 starts the next read byte. A stored SDA of 1 issues op 4 (NACK notice), after which clocks issue nothing and the drive stays 1 until START or STOP.
- R10: SDA rising while the stored SCL is 1 is STOP. It issues op 5 only when an address is latched, then drops the address and stops.
- R11: `sda_bus` is `sda_drive` ANDed with the stored controller SDA.
- R12: Operations appear only in the cycle of the triggering level change (or the cycle after a rejection), and `sda_drive` changes only at the clock edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the line levels |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sampled controller SCL level |
| sda_in | input | 1 | Sampled controller SDA level |
| sda_drive | output | 1 | Open-drain drive of the target, 1 = released |
| sda_bus | output | 1 | Resulting wire level, drive AND stored controller SDA |
| tgt_op | output | 3 | Downstream operation: 0 none, 1 start, 2 write, 3 read, 4 NACK notice, 5 end |
| tgt_addr | output | DATA_W-1 | 7-bit address, valid with op 1 |
| tgt_rnw | output | 1 | Read flag of the address, valid with op 1 |
| tgt_wdata | output | DATA_W | Write byte, valid with op 2 |
| tgt_accept | input | 1 | Same-cycle answer to op 1 or 2, 1 = accept |
| tgt_rdata | input | DATA_W | Read byte, taken in the cycle of op 3 |

## Verification
An operation is due combinationally in the same cycle as the level change that triggers it. The bench samples `tgt_op` and its fields 1 ns after driving the lines, before the next rising clock edge. The drive and bus results are due one clock edge later, so the bench reads them at the following falling edge. It also reads the drive before that edge to confirm that nothing changed early. The end transfer that follows a rejection is due one cycle after the rejecting edge, so it is checked on the next line event.

// File: rtl/i2cbt_pkg.sv
// Shared types of the I2C bit-level target bridge.
package i2cbt_pkg;
    // Protocol phase of the bridge.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // stopped, clocks ignored
        ST_RECV = 3'd1,   // shifting in address or write bits
        ST_ACKW = 3'd2,   // next rise hands the byte downstream
        ST_SEND = 3'd3,   // shifting out read bits
        ST_HACK = 3'd4,   // next rise samples controller acknowledge
        ST_PARK = 3'd5    // controller refused, clocks ignored
    } state_t;

    // Downstream operation codes (encoding is visible at the port).
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_START = 3'd1,
        OP_WRITE = 3'd2,
        OP_READ  = 3'd3,
        OP_NACK  = 3'd4,
        OP_END   = 3'd5
    } op_t;
endpackage

// File: rtl/i2cbt_lines.sv
// Line tracker: stores the last seen SCL/SDA levels and reports changes.
// Assumes scl_in/sda_in are already synchronous to clk.
module i2cbt_lines (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_chg;

    // Store the line levels; both idle high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    // Classify this cycle's level changes against the stored levels.
    always_comb begin
        sda_chg   = (sda_in != sda_q);
        start_det = sda_chg && scl_q && !sda_in;
        stop_det  = sda_chg && scl_q && sda_in;
        scl_rise  = scl_in && !scl_q;
        scl_fall  = !scl_in && scl_q;
    end

    AST_COND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det)); // R2
endmodule

// File: rtl/i2cbt_shreg.sv
// Byte register: shifts in received bits, loads and shifts out read bytes.
// Assumes at most one of the enables is set per cycle (load has priority).
module i2cbt_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_en,
    input  logic         cap_bit,
    input  logic         adv_en,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q
);
    // Update the byte: load keeps the bits after the MSB, capture adds at LSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load_en) begin
            q <= {load_val[W-2:0], 1'b0};
        end else if (cap_en) begin
            q <= {q[W-2:0], cap_bit};
        end else if (adv_en) begin
            q <= {q[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/i2cbt_ctrl.sv
// Protocol sequencer: walks receive, acknowledge and read phases, issues
// downstream operations and computes the open-drain drive.
// Assumes the downstream answer (accept, read MSB) is valid in the op cycle.
module i2cbt_ctrl
    import i2cbt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic start_det,
    input  logic stop_det,
    input  logic sda_bit,
    input  logic byte_lsb,
    input  logic byte_msb,
    input  logic tgt_accept,
    input  logic rd_msb,
    output op_t  op,
    output logic drive_q,
    output logic cap_en,
    output logic adv_en,
    output logic load_en
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    state_t           state, st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             addr_valid, av_n;
    logic             end_pend, pend_n;
    logic             drv_n;

    // Next-state, drive and operation decode for this cycle's line event.
    always_comb begin
        st_n    = state;
        cnt_n   = cnt;
        av_n    = addr_valid;
        drv_n   = drive_q;
        pend_n  = 1'b0;
        op      = end_pend ? OP_END : OP_NONE;
        cap_en  = 1'b0;
        adv_en  = 1'b0;
        load_en = 1'b0;
        if (start_det) begin
            st_n  = ST_RECV;
            cnt_n = '0;
            av_n  = 1'b0;
            drv_n = 1'b1;
        end else if (stop_det) begin
            if (addr_valid) op = OP_END;
            av_n  = 1'b0;
            st_n  = ST_IDLE;
            drv_n = 1'b1;
        end else if (scl_fall) begin
            drv_n = 1'b1;
        end else if (scl_rise) begin
            case (state)
                ST_RECV: begin
                    cap_en = 1'b1;
                    drv_n  = 1'b1;
                    if (cnt == LAST) begin
                        st_n  = ST_ACKW;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end
                ST_ACKW: begin
                    if (!addr_valid) begin
                        op   = OP_START;
                        av_n = 1'b1;
                    end else begin
                        op = OP_WRITE;
                    end
                    if (!tgt_accept) begin
                        drv_n  = 1'b1;
                        st_n   = ST_IDLE;
                        av_n   = 1'b0;
                        pend_n = 1'b1;
                    end else begin
                        drv_n = 1'b0;
                        cnt_n = '0;
                        st_n  = (!addr_valid && byte_lsb) ? ST_SEND : ST_RECV;
                    end
                end
                ST_SEND: begin
                    if (cnt == '0) begin
                        op      = OP_READ;
                        load_en = 1'b1;
                        drv_n   = rd_msb;
                    end else begin
                        adv_en = 1'b1;
                        drv_n  = byte_msb;
                    end
                    if (cnt == LAST) begin
                        st_n  = ST_HACK;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end
                ST_HACK: begin
                    drv_n = 1'b1;
                    if (sda_bit) begin
                        op   = OP_NACK;
                        st_n = ST_PARK;
                    end else begin
                        st_n  = ST_SEND;
                        cnt_n = '0;
                    end
                end
                default: drv_n = 1'b1;
            endcase
        end
    end

    // Commit phase, bit count, address flag, pending end and drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            addr_valid <= 1'b0;
            end_pend   <= 1'b0;
            drive_q    <= 1'b1;
        end else begin
            state      <= st_n;
            cnt        <= cnt_n;
            addr_valid <= av_n;
            end_pend   <= pend_n;
            drive_q    <= drv_n;
        end
    end

    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RECV && !addr_valid && cnt == '0)); // R2
    AST_FALL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |=> drive_q); // R4
    AST_ACCEPT_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_START || op == OP_WRITE) && tgt_accept) |=> !drive_q); // R6
    AST_REJECT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_START || op == OP_WRITE) && !tgt_accept)
            |=> (drive_q && state == ST_IDLE && op == OP_END)); // R7
    AST_READ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_READ) |-> scl_rise); // R8
    AST_QUIET_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE || state == ST_PARK) && scl_rise && !end_pend)
            |-> (op == OP_NONE)); // R9
    AST_END_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !addr_valid && !end_pend) |-> (op == OP_NONE)); // R10
endmodule

// File: rtl/i2c_bit_target.sv
// Top of the I2C bit-level target bridge: line tracker, byte register and
// protocol sequencer. Assumes sampled, glitch-free line levels and a
// downstream target that answers in the cycle of each operation.
module i2c_bit_target #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_drive,
    output logic              sda_bus,
    output logic [2:0]        tgt_op,
    output logic [DATA_W-2:0] tgt_addr,
    output logic              tgt_rnw,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic              tgt_accept,
    input  logic [DATA_W-1:0] tgt_rdata
);
    import i2cbt_pkg::*;

    localparam int ADDR_W = DATA_W - 1;

    logic              sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic              cap_en, adv_en, load_en;
    logic [DATA_W-1:0] byte_q;
    op_t               op_w;

    i2cbt_lines u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cbt_shreg #(.W(DATA_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .cap_bit  (sda_q),
        .adv_en   (adv_en),
        .load_en  (load_en),
        .load_val (tgt_rdata),
        .q        (byte_q)
    );

    i2cbt_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .sda_bit    (sda_q),
        .byte_lsb   (byte_q[0]),
        .byte_msb   (byte_q[DATA_W-1]),
        .tgt_accept (tgt_accept),
        .rd_msb     (tgt_rdata[DATA_W-1]),
        .op         (op_w),
        .drive_q    (sda_drive),
        .cap_en     (cap_en),
        .adv_en     (adv_en),
        .load_en    (load_en)
    );

    // Present the operation and the received byte fields downstream.
    always_comb begin
        tgt_op    = op_w;
        tgt_addr  = byte_q[DATA_W-1 -: ADDR_W];
        tgt_rnw   = byte_q[0];
        tgt_wdata = byte_q;
        sda_bus   = sda_drive & sda_q;
    end

    AST_BUS_PULLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sda_drive |-> !sda_bus); // R11
endmodule

// File: tb/i2c_bit_target_bench.sv
module i2c_bit_target_bench;
    localparam int CLK_P = 10;
    localparam logic [6:0] DEV_ADDR = 7'h50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_i = 1'b1, sda_i = 1'b1;
    logic       sda_drive, sda_bus, tgt_rnw, tgt_accept;
    logic [2:0] tgt_op;
    logic [6:0] tgt_addr;
    logic [7:0] tgt_wdata, tgt_rdata;
    logic [7:0] rd_val = 8'h00;

    int   n_tests = 0, n_fail = 0;
    logic cur_scl = 1'b1, cur_sda = 1'b1;
    logic allow_op = 1'b0;
    logic [2:0] cap_op;
    logic [6:0] cap_addr;
    logic       cap_rnw, cap_pre, cap_drive, cap_bus;
    logic [7:0] cap_wdata;

    always #(CLK_P/2) clk = ~clk;

    i2c_bit_target u_i2c_bit_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
        .sda_drive(sda_drive), .sda_bus(sda_bus), .tgt_op(tgt_op),
        .tgt_addr(tgt_addr), .tgt_rnw(tgt_rnw), .tgt_wdata(tgt_wdata),
        .tgt_accept(tgt_accept), .tgt_rdata(tgt_rdata)
    );

    // Expected downstream answers (scoreboard target model).
    function automatic logic exp_addr_ok(input logic [6:0] a);
        return a == DEV_ADDR;
    endfunction
    function automatic logic exp_data_ok(input logic [7:0] d);
        return d != 8'hFF;
    endfunction

    always_comb begin
        tgt_accept = 1'b1;
        if (tgt_op == 3'd1) tgt_accept = exp_addr_ok(tgt_addr);
        else if (tgt_op == 3'd2) tgt_accept = exp_data_ok(tgt_wdata);
        tgt_rdata = rd_val;
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One line event: drive levels, capture op before the edge, results after.
    task automatic ev(input logic s, input logic d);
        scl_i = s; sda_i = d; cur_scl = s; cur_sda = d;
        #1;
        cap_op = tgt_op; cap_addr = tgt_addr; cap_rnw = tgt_rnw;
        cap_wdata = tgt_wdata; cap_pre = sda_drive;
        if (cap_op != 3'd0 && !allow_op)
            check_eq("R12", "unexpected op", cap_op, 0);
        @(negedge clk);
        cap_drive = sda_drive; cap_bus = sda_bus;
    endtask

    task automatic c_start();
        if (!cur_scl) begin ev(1'b0, 1'b1); ev(1'b1, 1'b1); end
        ev(1'b1, 1'b0);
        check_eq("R2", "drive after START", cap_drive, 1);
        ev(1'b0, 1'b0);
    endtask

    task automatic c_stop(input logic exp_end);
        if (cur_scl) ev(1'b0, cur_sda);
        ev(1'b0, 1'b0);
        ev(1'b1, 1'b0);
        allow_op = 1'b1;
        ev(1'b1, 1'b1);
        allow_op = 1'b0;
        check_eq("R10", "op at STOP", cap_op, exp_end ? 5 : 0);
    endtask

    // Controller sends a byte; returns whether the bridge acknowledged.
    task automatic c_byte_out(input logic [7:0] b, input logic is_addr, output logic ok);
        logic bad_bus, bad_drv;
        bad_bus = 1'b0; bad_drv = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            ev(1'b0, b[i]);
            ev(1'b1, b[i]);
            if (cap_bus != b[i]) bad_bus = 1'b1;
            if (cap_drive != 1'b1) bad_drv = 1'b1;
            ev(1'b0, b[i]);
        end
        check_eq("R11", "bus follows controller bits", bad_bus, 0);
        check_eq("R5", "drive released while receiving", bad_drv, 0);
        ev(1'b0, 1'b1);
        allow_op = 1'b1;
        ev(1'b1, 1'b1);
        allow_op = 1'b0;
        if (is_addr) begin
            ok = exp_addr_ok(b[7:1]);
            check_eq("R5", "start op", cap_op, 1);
            check_eq("R5", "address", cap_addr, b[7:1]);
            check_eq("R5", "rnw", cap_rnw, b[0]);
        end else begin
            ok = exp_data_ok(b);
            check_eq("R5", "write op", cap_op, 2);
            check_eq("R5", "write data", cap_wdata, b);
        end
        check_eq("R12", "drive before edge", cap_pre, 1);
        check_eq(ok ? "R6" : "R7", "ack drive", cap_drive, ok ? 0 : 1);
        check_eq("R11", "bus during ack", cap_bus, ok ? 0 : 1);
        allow_op = !ok;
        ev(1'b0, 1'b1);
        allow_op = 1'b0;
        if (!ok) check_eq("R7", "end after reject", cap_op, 5);
        check_eq("R4", "release on fall", cap_drive, 1);
    endtask

    // Controller reads a byte and answers with ack (0) or nack (1).
    task automatic c_byte_in(input logic [7:0] val, input logic nack);
        logic [7:0] got;
        logic bad_drv;
        bad_drv = 1'b0;
        rd_val = val;
        for (int i = 7; i >= 0; i--) begin
            ev(1'b0, 1'b1);
            allow_op = (i == 7);
            ev(1'b1, 1'b1);
            allow_op = 1'b0;
            if (i == 7) check_eq("R8", "read op", cap_op, 3);
            got[i] = cap_bus;
            ev(1'b0, 1'b1);
            if (cap_drive != 1'b1) bad_drv = 1'b1;
        end
        check_eq("R8", "read bits", got, val);
        check_eq("R4", "release after read bits", bad_drv, 0);
        ev(1'b0, nack);
        allow_op = nack;
        ev(1'b1, nack);
        allow_op = 1'b0;
        check_eq("R9", "op at controller ack", cap_op, nack ? 4 : 0);
        ev(1'b0, nack);
    endtask

    // Clock pulses that a parked or stopped bridge must ignore.
    task automatic quiet_pulses(input string req);
        logic bad;
        bad = 1'b0;
        for (int k = 0; k < 3; k++) begin
            ev(1'b1, cur_sda);
            if (cap_drive != 1'b1) bad = 1'b1;
            ev(1'b0, cur_sda);
        end
        check_eq(req, "drive stays released", bad, 0);
    endtask

    task automatic write_txn(input logic [6:0] a, input int n);
        logic ok;
        logic [7:0] d;
        c_start();
        c_byte_out({a, 1'b0}, 1'b1, ok);
        for (int k = 0; k < n && ok; k++) begin
            d = ($urandom % 6 == 0) ? 8'hFF : 8'($urandom);
            c_byte_out(d, 1'b0, ok);
        end
        if (!ok) quiet_pulses("R7");
        c_stop(ok);
    endtask

    task automatic read_txn(input logic [6:0] a, input int n);
        logic ok;
        c_start();
        c_byte_out({a, 1'b1}, 1'b1, ok);
        if (ok) begin
            for (int k = 0; k < n; k++) c_byte_in(8'($urandom), k == n - 1);
            quiet_pulses("R9");
        end else begin
            quiet_pulses("R7");
        end
        c_stop(ok);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic ok;
        void'($urandom(32'd24681));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "drive at reset", sda_drive, 1);
        check_eq("R1", "bus at reset", sda_bus, 1);
        check_eq("R1", "op at reset", tgt_op, 0);

        // R3: SDA wiggles with SCL low and repeated levels do nothing.
        ev(1'b0, 1'b1); ev(1'b0, 1'b0); ev(1'b0, 1'b0); ev(1'b0, 1'b1); ev(1'b0, 1'b1);
        check_eq("R3", "drive after low-clock SDA moves", cap_drive, 1);
        quiet_pulses("R3");
        c_stop(1'b0);

        // Directed: write, absent address, data reject, read ended by NACK.
        write_txn(DEV_ADDR, 3);
        write_txn(DEV_ADDR ^ 7'h01, 2);
        c_start();
        c_byte_out({DEV_ADDR, 1'b0}, 1'b1, ok);
        c_byte_out(8'hFF, 1'b0, ok);
        check_eq("R7", "data reject reported", ok, 0);
        quiet_pulses("R7");
        c_stop(1'b0);
        read_txn(DEV_ADDR, 3);
        read_txn(DEV_ADDR ^ 7'h10, 1);

        // Directed: repeated START between a write and a read (R2).
        c_start();
        c_byte_out({DEV_ADDR, 1'b0}, 1'b1, ok);
        c_byte_out(8'h3C, 1'b0, ok);
        c_start();
        c_byte_out({DEV_ADDR, 1'b1}, 1'b1, ok);
        check_eq("R2", "fresh start after repeat", ok, 1);
        c_byte_in(8'h81, 1'b0);
        c_byte_in(8'h7E, 1'b1);
        c_stop(1'b1);

        // Random mix of transactions.
        for (int t = 0; t < 30; t++) begin
            logic [6:0] a;
            a = ($urandom % 4 == 0) ? 7'($urandom) : DEV_ADDR;
            if ($urandom % 2 == 0) write_txn(a, 1 + int'($urandom % 4));
            else read_txn(a, 1 + int'($urandom % 4));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule